// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

An 8-bit general-purpose I/O port controller with three registers on a simple register bus. The three registers hold the output latch, the per-pin direction bits and the per-pin reduced-drive selects. The block drives a per-pin output enable, an output value and a reduced-drive select toward the pads. Pin levels coming in from the pads pass through a two-stage synchronizer before they can be read.

Each pin can be claimed by an enabled on-chip peripheral. While a peripheral claims a pin, it sets that pin's direction through an override-enable and override-direction pair. The stored direction bit is left untouched. Once the claim is dropped, the pin follows its stored bit again. Software may read and write all three registers at any time, including while an override is active.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction, output-latch and drive registers all read 0. oe_o and rdrv_o are 0, so every pin is an input at full drive.
- R2: A one-cycle write strobe stores wdata_i into the register selected by addr_i: 0 is the output latch, 1 is direction and 2 is reduced drive. Reads are combinational on addr_i, and address 3 reads 0.
- R3: With no override on a pin, oe_o for that pin equals its direction bit, where 1 means output and 0 means input.
- R4: While ovr_en_i is 1 for a pin, oe_o for that pin equals ovr_dir_i for that pin, whatever the stored direction bit.
- R5: An override never modifies the stored direction bits. Reading address 1 returns the last written value, and after release oe_o follows the stored bits again.
- R6: A direction write made during an override is stored, has no effect on oe_o while the override holds, and takes effect once the override is released.
- R7: A read of address 0 returns the output latch bit for pins whose effective direction is output. For pins whose effective direction is input, it returns the synchronized pin level.
- R8: A change on pin_i becomes visible in an address-0 read of an input pin after exactly two rising clock edges, and not after one.
- R9: rdrv_o for a pin equals its drive register bit when the pin is effectively an output, and 0 when it is effectively an input.
- R10: out_o always equals the output latch, whatever the effective direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| pin_i | input | 8 | Pad input levels, asynchronous |
| ovr_en_i | input | 8 | Per-pin peripheral override enable |
| ovr_dir_i | input | 8 | Per-pin forced direction (1 = output) |
| oe_o | output | 8 | Effective per-pin output enable |
| out_o | output | 8 | Per-pin output value |
| rdrv_o | output | 8 | Per-pin reduced-drive select |

## Verification
The assertions assume a few things about the inputs. wr_en_i and addr_i are stable around the clock edge. pin_i is sampled only at rising edges, so the two-edge latency check is meaningful only when pin levels change away from the edge. The override inputs are treated as level signals that may change in any cycle. To stay within these assumptions, the stimulus drives every input, including pin_i and the override pair, on the falling edge only. It samples every output half a period after each rising edge.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NREG   = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_DRV  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      data_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      drv_o
);
  logic [N-1:0] reg_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  reg_q[k] <= '0;
      else if (hit) reg_q[k] <= wdata_i;
    end
  end

  assign data_o = reg_q[REG_DATA];
  assign dir_o  = reg_q[REG_DIR];
  assign drv_o  = reg_q[REG_DRV];

  // direction bits only move on a direction write (never from an override)
  p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_DIR) |=> $stable(dir_o));

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);
  localparam int unsigned CNT_W = $clog2(STAGES + 1);

  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [N-1:0] d;
    if (s == 0) begin : g_first
      assign d = pin_i;
    end else begin : g_next
      assign d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= d;
    end
  end

  assign pin_o = stg_q[STAGES-1];

  // edges since reset, saturating, for the latency check
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    age_q <= '0;
    else if (age_q != CNT_W'(STAGES)) age_q <= age_q + 1'b1;
  end

  if (STAGES == 2) begin : g_chk
    p_sync_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == CNT_W'(STAGES)) |-> (pin_o == $past(pin_i, 2)));
  end
endmodule

// File: rtl/gpio_ovr_dir.sv
module gpio_ovr_dir #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] drv_i,
  input  logic [N-1:0] ovr_en_i,
  input  logic [N-1:0] ovr_dir_i,
  output logic [N-1:0] oe_o,
  output logic [N-1:0] rdrv_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign oe_o[i]   = ovr_en_i[i] ? ovr_dir_i[i] : dir_i[i];
    assign rdrv_o[i] = drv_i[i] & oe_o[i];
  end

  // reduced drive never asserted on an input pin
  p_rdrv_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdrv_o & ~oe_o) == '0);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      pin_i,
  input  logic [N-1:0]      ovr_en_i,
  input  logic [N-1:0]      ovr_dir_i,
  output logic [N-1:0]      oe_o,
  output logic [N-1:0]      out_o,
  output logic [N-1:0]      rdrv_o
);
  logic [N-1:0] data_q, dir_q, drv_q, pin_s;

  gpio_ovr_regs #(.N(N)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .data_o(data_q), .dir_o(dir_q), .drv_o(drv_q)
  );

  gpio_ovr_sync #(.N(N), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pin_o(pin_s)
  );

  gpio_ovr_dir #(.N(N)) u_dir (
    .clk_i, .rst_ni, .dir_i(dir_q), .drv_i(drv_q),
    .ovr_en_i, .ovr_dir_i, .oe_o, .rdrv_o
  );

  assign out_o = data_q;

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = (oe_o & data_q) | (~oe_o & pin_s);
      REG_DIR:  rdata_o = dir_q;
      REG_DRV:  rdata_o = drv_q;
      default:  rdata_o = '0;
    endcase
  end

  // with no override anywhere, the pad direction is the stored register
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_en_i == '0) |-> (oe_o == dir_q));

  p_rd_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_DATA) |-> ((rdata_o & oe_o) == (out_o & oe_o)));

  p_rd_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_DATA) |-> ((rdata_o & ~oe_o) == (pin_s & ~oe_o)));
endmodule

// File: tb/gpio_ovr_port_bench.sv
`timescale 1ns/1ps
module gpio_ovr_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = '0, pin_i = '0, ovr_en_i = '0, ovr_dir_i = '0;
  logic [7:0] rdata_o, oe_o, out_o, rdrv_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_ovr_port u_gpio_ovr_port (.*);

  // {dir, ovr_en, ovr_dir, data, drv, pin}
  localparam logic [47:0] VEC [8] = '{
    48'h00_00_00_00_00_5A,
    48'hFF_00_00_C3_F0_00,
    48'h0F_00_00_AA_FF_33,
    48'hF0_0F_0F_55_0F_CC,
    48'hFF_F0_00_96_FF_69,
    48'h3C_FF_A5_E7_5A_18,
    48'h00_81_81_FF_81_7E,
    48'hA5_00_00_0F_FF_F0
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr_i = a;
    #0.5;
    v = rdata_o;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 oe", oe_o, 8'h00);
    chk("R1 rdrv", rdrv_o, 8'h00);
    chk("R1 out", out_o, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 drv", v, 8'h00);
    rd(2'd0, v); chk("R1 data", v, 8'h00);

    foreach (VEC[k]) begin
      logic [7:0] dir, oen, odir, dat, drv, pin, eff;
      {dir, oen, odir, dat, drv, pin} = VEC[k];
      @(negedge clk_i);
      ovr_en_i = oen; ovr_dir_i = odir; pin_i = pin;
      wr(2'd1, dir);
      wr(2'd0, dat);
      wr(2'd2, drv);
      @(negedge clk_i);
      eff = (oen & odir) | (~oen & dir);
      chk("R3/R4 oe", oe_o, eff);
      chk("R10 out", out_o, dat);
      chk("R9 rdrv", rdrv_o, drv & eff);
      rd(2'd0, v); chk("R7 data read", v, (eff & dat) | (~eff & pin));
      rd(2'd1, v); chk("R5 dir readback", v, dir);
      rd(2'd2, v); chk("R2 drv readback", v, drv);
      rd(2'd3, v); chk("R2 unused addr", v, 8'h00);
    end

    // R8 sync latency: all inputs, no override
    @(negedge clk_i);
    ovr_en_i = 8'h00; pin_i = 8'h00;
    wr(2'd1, 8'h00);
    repeat (2) @(negedge clk_i);
    pin_i = 8'hA5;
    rd(2'd0, v); chk("R8 before edge", v, 8'h00);
    @(negedge clk_i);
    rd(2'd0, v); chk("R8 after one edge", v, 8'h00);
    @(negedge clk_i);
    rd(2'd0, v); chk("R8 after two edges", v, 8'hA5);

    // R6 direction write during override, then release
    ovr_en_i = 8'hFF; ovr_dir_i = 8'h00;
    wr(2'd1, 8'hFF);
    chk("R6 oe while overridden", oe_o, 8'h00);
    rd(2'd1, v); chk("R6 dir stored", v, 8'hFF);
    ovr_en_i = 8'h00;
    #0.5;
    chk("R6 oe after release", oe_o, 8'hFF);
    // R4 override to output on a stored-input pin
    wr(2'd1, 8'h00);
    ovr_en_i = 8'h0C; ovr_dir_i = 8'h0C;
    #0.5;
    chk("R4 forced output", oe_o, 8'h0C);
    rd(2'd1, v); chk("R5 dir untouched", v, 8'h00);
    ovr_en_i = 8'h00;
    #0.5;
    chk("R5 release", oe_o, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule